// File: doc/BRIEF.md
# Programmable Signal Routing Pool

This block is a configurable crosspoint that sits between a bank of N pad inputs and M output cells. Every pad first passes through its own capture stage, which can run straight through, hold the value in a register, or act as a transparent latch. The stage can be enabled on every clock or only by a shared dedicated strobe. The captured pad values form a pool from which each output cell takes four data legs and four control terminals: output enable, output latch gate, and two mux selects. The two selects pick one of the four legs. A pad can feed any number of cells at once.

The pool is partitioned. The pads are split into four equal groups by the top two bits of the pad index. Data leg k of a cell may only come from group k. The output-enable terminal may only come from group 0, the latch gate from group 1, select bit 0 from group 2 and select bit 1 from group 3. Every source field carries its own polarity bit. The routing image is loaded one field per write through a valid/ready port. The block never applies back-pressure, so `cfg_ready` stays high and every write presented with `cfg_valid` is taken on that clock edge. A write that breaks the grouping, uses a reserved mode code, or targets an unmapped address is dropped and raises a sticky error flag. N must be a power of two and at least 8, and M must be at least 2.

Write address map:
- Cell c, field f (f = 0..7) sits at address c*8+f.
  - Fields 0 to 3 are legs A to D.
  - Fields 4 to 7 are output enable, latch gate, select 0 and select 1.
- Pad p's capture mode sits at address M*8+p.

Top module: `route_pool`

## Requirements
- R1: A synchronous active-high `rst` sets every cell field to the lowest pad of its group with no inversion, sets every capture stage to direct mode with strobe-free enable, clears every capture and output-latch state bit, and clears `cfg_err`.
- R2: A cell field holds a pad index in bits [IW-1:0] and an inversion flag in bit IW. A term's value is the captured pad value XOR the flag. While the latch gate is 1, `cell_out` equals leg {sel1,sel0}, where leg 0 is A and leg 3 is D.
- R3: A write to a data-leg field k is accepted only if the top two index bits equal k. Otherwise the write is dropped, the stored field is unchanged, and `cfg_err` is 1 from the next cycle.
- R4: Control fields follow the same rule: output enable needs group 0, latch gate group 1, select 0 group 2 and select 1 group 3. Any other write is dropped and sets `cfg_err`.
- R5: One pad may be routed to any number of legs and cells at the same time.
- R6: While the latch gate term is 0, `cell_out` holds the value it had on the last cycle the gate was 1.
- R7: `cell_oe` equals the output-enable term.
- R8: Capture mode code 1 is a register. At each clock edge where capture is enabled, the stage takes the pad value, and it holds the value otherwise.
- R9: Capture mode code 2 is a latch. It passes the pad while capture is enabled and holds the last passed value while capture is disabled. Mode code 0 always passes the pad.
- R10: Mode-field bit 2 selects the enable source: 0 means always enabled, and 1 means enabled only while `dstb` is 1.
- R11: A capture-mode write with code 3, or any write to an address at or above M*8+N, is dropped and sets `cfg_err`.
- R12: `cfg_err` stays 1 until `rst`.
- R13: `cfg_ready` is always 1. An accepted write takes effect on the outputs in the cycle right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | N | Pad input values |
| dstb | input | 1 | Dedicated capture strobe |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready (always 1) |
| cfg_addr | input | AW | Field address |
| cfg_data | input | IW+1 | Field value: pad index plus inversion, or mode code plus strobe select |
| cfg_err | output | 1 | Sticky rejected-write flag |
| cell_out | output | M | Output cell data |
| cell_oe | output | M | Output cell enable |

## Verification
The hardest condition to reach is a rejected write observed on its own. Once any illegal write occurs, the sticky flag hides every later one. The bench therefore pulses reset before each directed illegal-write case, and it runs a long legal-only random phase before the mixed phase. The latch and register hold behaviour is only visible when the gate or strobe drops while the pad still changes. To reach it, the random stimulus keeps toggling the gate pads, `dstb` and the pads every cycle, and it rewrites capture modes between cycles so that a stage is often switched while holding a stale value.

// File: rtl/route_pool_pkg.sv
package route_pool_pkg;
  typedef enum logic [1:0] {
    CAP_DIRECT = 2'd0,
    CAP_REG    = 2'd1,
    CAP_LATCH  = 2'd2,
    CAP_RSVD   = 2'd3
  } cap_mode_e;

  localparam int FIELDS_PER_CELL = 8;
  localparam int TERM_OE   = 4;
  localparam int TERM_GATE = 5;
  localparam int TERM_SEL0 = 6;
  localparam int TERM_SEL1 = 7;
endpackage

// File: rtl/rp_capture.sv
module rp_capture
  import route_pool_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pad,
  input  logic      en,
  input  cap_mode_e mode,
  output logic      val
);
  logic st;

  always_comb begin
    case (mode)
      CAP_REG:   val = st;
      CAP_LATCH: val = en ? pad : st;
      default:   val = pad;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  st <= 1'b0;
    else if (mode == CAP_REG) st <= en ? pad : st;
    else                      st <= val;
  end

  AST_REG_TAKES_PAD: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_REG && en) |=> (mode != CAP_REG || val == $past(pad))); // R8
endmodule

// File: rtl/rp_cfg.sv
module rp_cfg #(
  parameter int N  = 16,
  parameter int M  = 4,
  parameter int IW = 4,
  parameter int AW = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_valid,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [IW:0]               cfg_data,
  output logic [M-1:0][7:0][IW:0]   fld,
  output logic [N-1:0][2:0]         pmode,
  output logic                      cfg_err
);
  localparam int QW       = IW - 2;
  localparam int CELL_END = M * 8;
  localparam int MAP_END  = M * 8 + N;
  localparam int CW       = $clog2(M);

  logic          legal, to_cell;
  logic [CW-1:0] wr_cell;
  logic [2:0]    wr_fld;
  logic [IW-1:0] wr_pad;

  always_comb begin
    to_cell = int'(cfg_addr) < CELL_END;
    wr_cell = CW'(cfg_addr >> 3);
    wr_fld  = cfg_addr[2:0];
    wr_pad  = IW'(int'(cfg_addr) - CELL_END);
    if (to_cell)                      legal = (cfg_data[IW-1:IW-2] == wr_fld[1:0]);
    else if (int'(cfg_addr) < MAP_END) legal = (cfg_data[1:0] != 2'd3);
    else                               legal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < M; c++)
        for (int f = 0; f < 8; f++)
          fld[c][f] <= {1'b0, 2'(f), {QW{1'b0}}};
      pmode   <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_valid) begin
      if (!legal)       cfg_err <= 1'b1;
      else if (to_cell) fld[wr_cell][wr_fld] <= cfg_data;
      else              pmode[wr_pad] <= cfg_data[2:0];
    end
  end

  AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !legal) |=> cfg_err); // R3
  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !legal) |=> ($stable(fld) && $stable(pmode))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R12
endmodule

// File: rtl/rp_cell.sv
module rp_cell
  import route_pool_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        cap,
  input  logic [7:0][IW:0]    cfg,
  output logic                out,
  output logic                oe
);
  logic [7:0] term;
  logic [3:0] legs;
  logic [1:0] sel;
  logic       gate, hold;

  for (genvar k = 0; k < FIELDS_PER_CELL; k++) begin : g_term
    assign term[k] = cap[cfg[k][IW-1:0]] ^ cfg[k][IW];
  end

  assign legs = term[3:0];
  assign sel  = {term[TERM_SEL1], term[TERM_SEL0]};
  assign gate = term[TERM_GATE];
  assign oe   = term[TERM_OE];
  assign out  = gate ? legs[sel] : hold;

  always_ff @(posedge clk) begin
    if (rst) hold <= 1'b0;
    else     hold <= out;
  end

  AST_CLOSED_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (gate || $stable(out))); // R6
endmodule

// File: rtl/route_pool.sv
module route_pool
  import route_pool_pkg::*;
#(
  parameter int N = 16,
  parameter int M = 4,
  localparam int IW = $clog2(N),
  localparam int AW = $clog2(M * 8 + N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pad_in,
  input  logic          dstb,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [AW-1:0] cfg_addr,
  input  logic [IW:0]   cfg_data,
  output logic          cfg_err,
  output logic [M-1:0]  cell_out,
  output logic [M-1:0]  cell_oe
);
  logic [M-1:0][7:0][IW:0] fld;
  logic [N-1:0][2:0]       pmode;
  logic [N-1:0]            cap;

  assign cfg_ready = 1'b1;

  rp_cfg #(.N(N), .M(M), .IW(IW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .fld(fld), .pmode(pmode), .cfg_err(cfg_err)
  );

  for (genvar p = 0; p < N; p++) begin : g_pad
    rp_capture u_cap (
      .clk(clk), .rst(rst), .pad(pad_in[p]),
      .en(pmode[p][2] ? dstb : 1'b1),
      .mode(cap_mode_e'(pmode[p][1:0])), .val(cap[p])
    );
  end

  for (genvar c = 0; c < M; c++) begin : g_cell
    rp_cell #(.N(N), .IW(IW)) u_cell (
      .clk(clk), .rst(rst), .cap(cap), .cfg(fld[c]),
      .out(cell_out[c]), .oe(cell_oe[c])
    );
  end
endmodule

// File: tb/route_pool_test.sv
`timescale 1ns/1ps
module route_pool_test;
  localparam int N = 16, M = 4;
  localparam int IW = $clog2(N);
  localparam int AW = $clog2(M * 8 + N + 1);
  localparam int Q = N / 4;

  logic clk = 0, rst = 1, dstb = 0, cfg_valid = 0;
  logic [N-1:0] pad = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [IW:0] cfg_data = '0;
  logic cfg_ready, cfg_err;
  logic [M-1:0] cell_out, cell_oe;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  route_pool #(.N(N), .M(M)) uut (
    .clk(clk), .rst(rst), .pad_in(pad), .dstb(dstb), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_err(cfg_err), .cell_out(cell_out), .cell_oe(cell_oe)
  );

  logic [IW:0] mf [M][8];
  logic [2:0] mm [N];
  logic [N-1:0] mst;
  logic [M-1:0] mhold;
  logic merr;

  function automatic void mreset();
    for (int c = 0; c < M; c++)
      for (int f = 0; f < 8; f++) mf[c][f] = {1'b0, IW'((f % 4) * Q)};
    for (int p = 0; p < N; p++) mm[p] = 3'd0;
    mst = '0; mhold = '0; merr = 0;
  endfunction

  function automatic logic en_of(int p);
    return mm[p][2] ? dstb : 1'b1;
  endfunction

  function automatic logic [N-1:0] capv();
    logic [N-1:0] v;
    for (int p = 0; p < N; p++)
      case (mm[p][1:0])
        2'd1: v[p] = mst[p];
        2'd2: v[p] = en_of(p) ? pad[p] : mst[p];
        default: v[p] = pad[p];
      endcase
    return v;
  endfunction

  function automatic logic legal(int a, logic [IW:0] d);
    if (a < M * 8) return int'(d[IW-1:0]) / Q == (a % 8) % 4;
    if (a < M * 8 + N) return d[1:0] != 2'd3;
    return 0;
  endfunction

  task automatic check(string tag, string what, logic [M-1:0] act, logic [M-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] cv;
    logic [M-1:0] eo, eoe;
    logic t [8];
    #1;
    cv = capv();
    for (int c = 0; c < M; c++) begin
      for (int k = 0; k < 8; k++) t[k] = cv[mf[c][k][IW-1:0]] ^ mf[c][k][IW];
      eoe[c] = t[4];
      eo[c] = t[5] ? t[{t[7], t[6]}] : mhold[c];
    end
    if (!rst) begin
      check(tag, "cell_out", cell_out, eo);
      check(tag, "cell_oe", cell_oe, eoe);
      check(tag, "cfg_err", M'(cfg_err), M'(merr));
      check("R13", "cfg_ready", M'(cfg_ready), M'(1));
    end
    @(posedge clk);
    if (rst) mreset();
    else begin
      for (int p = 0; p < N; p++)
        if (mm[p][1:0] == 2'd1) begin if (en_of(p)) mst[p] = pad[p]; end
        else mst[p] = cv[p];
      mhold = eo;
      if (cfg_valid) begin
        if (!legal(int'(cfg_addr), cfg_data)) merr = 1;
        else if (int'(cfg_addr) < M * 8) mf[int'(cfg_addr) / 8][int'(cfg_addr) % 8] = cfg_data;
        else mm[int'(cfg_addr) - M * 8] = cfg_data[2:0];
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(int a, int d, string tag);
    cfg_valid = 1; cfg_addr = AW'(a); cfg_data = (IW + 1)'(d);
    step(tag);
    cfg_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1; step("R1"); step("R1"); rst = 0;
  endtask

  task automatic rand_cycle(bit allow_bad);
    int a, f, r;
    pad = N'($urandom); dstb = 1'($urandom);
    r = $urandom % 10;
    if (r < 3) begin
      cfg_valid = 1;
      if (allow_bad && r == 0) begin
        cfg_addr = AW'($urandom); cfg_data = (IW + 1)'($urandom);
      end else if (r == 1) begin
        a = M * 8 + int'($urandom % N);
        cfg_addr = AW'(a); cfg_data = {1'b0, IW'($urandom % 3)} | (IW + 1)'($urandom & 4);
      end else begin
        f = $urandom % 8;
        a = int'($urandom % M) * 8 + f;
        cfg_addr = AW'(a);
        cfg_data = {1'($urandom), IW'((f % 4) * Q + int'($urandom % Q))};
      end
    end else cfg_valid = 0;
    step(allow_bad ? "R11" : "R2");
    cfg_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    mreset();
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 3; i++) begin pad = N'($urandom); step("R1"); end
    // R13 / R2: cell0 leg B from pad Q+1, select = 1, gate open
    wr(1, Q + 1, "R13");
    pad = '0; pad[Q] = 1; pad[2 * Q] = 1; pad[Q + 1] = 1; step("R2");
    pad[Q + 1] = 0; step("R2");
    // R5: pad 3 drives leg A of every cell, one inverted
    for (int c = 0; c < M; c++) wr(c * 8, (c == 2) ? (1 << IW) | 3 : 3, "R5");
    pad = '0; pad[Q] = 1;
    for (int i = 0; i < 4; i++) begin pad[3] = 1'(i); step("R5"); end
    // R6: gate closed, data toggles
    pad[3] = 1; step("R6"); pad[Q] = 0;
    for (int i = 0; i < 4; i++) begin pad[3] = 1'(i); step("R6"); end
    // R7: cell1 output enable from pad 2 inverted
    wr(8 + 4, (1 << IW) | 2, "R7");
    for (int i = 0; i < 3; i++) begin pad = N'($urandom); step("R7"); end
    // R8: pad 3 registered, always enabled
    wr(M * 8 + 3, 1, "R8"); pad[Q] = 1;
    for (int i = 0; i < 6; i++) begin pad[3] = 1'($urandom); step("R8"); end
    // R9 / R10: pad 3 latched, enabled by strobe
    wr(M * 8 + 3, 6, "R10");
    for (int i = 0; i < 8; i++) begin pad[3] = 1'($urandom); dstb = 1'(i < 2 || i > 5); step("R9"); end
    wr(M * 8 + 3, 5, "R10");
    for (int i = 0; i < 6; i++) begin pad[3] = 1'($urandom); dstb = 1'($urandom); step("R10"); end
    // R3: illegal leg write
    wr(0, Q + 1, "R3"); step("R3");
    for (int i = 0; i < 3; i++) begin wr(1, Q, "R12"); end
    step("R12");
    do_reset(); step("R12");
    // R4: illegal control write
    wr(8 + 6, 1, "R4"); step("R4"); do_reset();
    // R11: reserved mode code, then unmapped address
    wr(M * 8 + 5, 3, "R11"); step("R11"); do_reset();
    wr(M * 8 + N, 0, "R11"); step("R11"); do_reset();
    for (int i = 0; i < 600; i++) rand_cycle(0);
    do_reset();
    for (int i = 0; i < 1500; i++) rand_cycle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule